// File: doc/BRIEF.md
# Sequential AES round-key generator

This unit turns a 128-, 192- or 256-bit cipher key into the full AES round-key schedule. It produces one 32-bit column per clock and keeps every column in an internal array. The columns stay there, and serve every data block, until the key is withdrawn. The key size is fixed at elaboration by `KEY_BITS`. From it follow the key length in words (Nk = 4, 6, 8), the round count (Nr = 10, 12, 14) and the number of stored columns (4·(Nr+1)).

A pulse on `start_i` captures `key_i`. In the same edge it writes round key 0, which is the leading four words of the key. It then fills the remaining columns one per cycle. Columns below Nk are copied from the captured key. The others are derived from the previous column and from the column Nk places back. `ready_o` rises once the last column is written. Encrypt and decrypt datapaths share one read port. The port returns a 128-bit round key chosen by index, and its reverse input maps index r to round Nr−r, so a decryptor can count upward as well. Pulsing `invalidate_i` withdraws the key, and any expansion still in progress stops. A new `start_i` is honoured only after that.

Top module: `aes_key_expand`

## Requirements
- R1: After reset, `ready_o` is 0 and `rd_key_o` is all zeros.
- R2: Key word k is `key_i[KEY_BITS-1-32k -: 32]`. Round key 0 equals the leading 128 bits of the key. Columns 0 to Nk−1 equal the key words in order. `rd_key_o` carries column 4r in bits 127:96 down to column 4r+3 in bits 31:0.
- R3: Take column i ≥ Nk, with p = column i−1. When i mod Nk = 0, the column equals column i−Nk XOR SubWord(RotWord(p)) XOR {rc, 24'h0}. RotWord moves the top byte to the bottom. rc starts at 8'h01 and is doubled in GF(2^8) (polynomial 8'h1b) for each further use. Otherwise the column is column i−Nk XOR p.
- R4: For 256-bit keys, a column with i mod 8 = 4 equals column i−8 XOR SubWord(p).
- R5: `ready_o` becomes 1 exactly 4·Nr clock edges after the edge that accepts `start_i` (40, 48 or 56), and is 0 one edge earlier.
- R6: While `ready_o` stays 1, the round keys keep their values for any later read.
- R7: With `rd_reverse_i` = 1, index r returns round key Nr−r. With 0, it returns round key r.
- R8: `invalidate_i` sampled 1 clears `ready_o` at that edge and stops a running expansion, which never reaches ready. `rd_key_o` is all zeros whenever `ready_o` is 0.
- R9: `start_i` is ignored while an expansion runs or while `ready_o` is 1. A changed `key_i` then has no effect.
- R10: An index greater than Nr returns all zeros, in either direction.
- R11: After an invalidate, a fresh `start_i` expands the key then present on `key_i`.
- R12: When `start_i` and `invalidate_i` are both 1 on the same edge, the invalidate wins and no expansion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | KEY_BITS | Cipher key, word 0 in the top bits |
| start_i | input | 1 | Begin expansion of `key_i` |
| invalidate_i | input | 1 | Withdraw key, clear ready, abort expansion |
| ready_o | output | 1 | All round keys present |
| rd_round_i | input | RIDX_W | Round index of the read port |
| rd_reverse_i | input | 1 | Map index r to round Nr−r |
| rd_key_o | output | 128 | Selected round key, zero when not ready or out of range |

## Verification
The assertions assume a few things about the inputs. `start_i` counts only when no expansion is running, `ready_o` is low and no invalidate is present; the checker's cycle counter follows that same acceptance rule. Holding `rd_round_i` and `rd_reverse_i` steady is assumed to be all a requester needs for an unchanged key. The directed stimulus drives inputs only on falling edges. It applies `start_i` for single cycles, including pulses deliberately placed during an expansion and after ready, and it tests invalidate both alone and together with start. All three key sizes run side by side from the same control inputs.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

  localparam logic [7:0] GF_POLY = 8'h1b;
  localparam logic [7:0] INV_EXP = 8'hfe;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? GF_POLY : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254, then the affine map
  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] v;
    v = 8'h01;
    for (int k = 7; k >= 0; k--) begin
      v = gf_mul(v, v);
      if (INV_EXP[k]) v = gf_mul(v, x);
    end
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] sub_word(input logic [31:0] w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = sbox(w[8*k +: 8]);
    return r;
  endfunction

  function automatic logic [31:0] rot_word(input logic [31:0] w);
    return {w[23:0], w[31:24]};
  endfunction

endpackage

// File: rtl/aes_kx_colgen.sv
module aes_kx_colgen
  import aes_kx_pkg::*;
#(
  parameter int NK   = 4,
  parameter int PH_W = 2
) (
  input  logic [31:0]     prev_i,
  input  logic [31:0]     back_i,
  input  logic [31:0]     key_col_i,
  input  logic            copy_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic [7:0]      rcon_i,
  output logic [31:0]     col_o
);

  logic [31:0] mix;

  generate
    if (NK > 6) begin : g_wide
      always_comb begin
        if (phase_i == '0)                 mix = sub_word(rot_word(prev_i)) ^ {rcon_i, 24'h0};
        else if (phase_i == PH_W'(4))      mix = sub_word(prev_i);
        else                               mix = prev_i;
      end
    end else begin : g_narrow
      always_comb begin
        if (phase_i == '0) mix = sub_word(rot_word(prev_i)) ^ {rcon_i, 24'h0};
        else               mix = prev_i;
      end
    end
  endgenerate

  assign col_o = copy_i ? key_col_i : (back_i ^ mix);

endmodule

// File: rtl/aes_kx_store.sv
module aes_kx_store #(
  parameter int NCOL   = 44,
  parameter int NR     = 10,
  parameter int AW     = 6,
  parameter int RIDX_W = 4
) (
  input  logic              clk_i,
  input  logic              init_i,
  input  logic [127:0]      init_key_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [31:0]       wdata_i,
  input  logic [AW-1:0]     prev_addr_i,
  input  logic [AW-1:0]     back_addr_i,
  output logic [31:0]       prev_o,
  output logic [31:0]       back_o,
  input  logic              valid_i,
  input  logic [RIDX_W-1:0] round_i,
  input  logic              reverse_i,
  output logic [127:0]      rkey_o
);

  logic [31:0]       mem [NCOL];
  logic [RIDX_W-1:0] eff;
  logic [AW-1:0]     base;
  logic              in_range;

  always_ff @(posedge clk_i) begin
    if (init_i) begin
      for (int g = 0; g < 4; g++) mem[g] <= init_key_i[127-32*g -: 32];
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign prev_o = mem[prev_addr_i];
  assign back_o = mem[back_addr_i];

  assign in_range = (round_i <= RIDX_W'(NR));
  assign eff      = reverse_i ? (RIDX_W'(NR) - round_i) : round_i;
  assign base     = AW'({eff, 2'b00});

  assign rkey_o = (valid_i && in_range)
                ? {mem[base], mem[base + AW'(1)], mem[base + AW'(2)], mem[base + AW'(3)]}
                : '0;

endmodule

// File: rtl/aes_key_expand.sv
module aes_key_expand
  import aes_kx_pkg::*;
#(
  parameter  int KEY_BITS = 128,
  localparam int NK       = KEY_BITS / 32,
  localparam int NR       = NK + 6,
  localparam int NCOL     = 4 * (NR + 1),
  localparam int AW       = $clog2(NCOL),
  localparam int RIDX_W   = $clog2(NR + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [KEY_BITS-1:0] key_i,
  input  logic                start_i,
  input  logic                invalidate_i,
  output logic                ready_o,
  input  logic [RIDX_W-1:0]   rd_round_i,
  input  logic                rd_reverse_i,
  output logic [127:0]        rd_key_o
);

  localparam int PH_W = $clog2(NK);

  logic                busy_q, ready_q;
  logic [AW-1:0]       cnt_q;
  logic [PH_W-1:0]     phase_q;
  logic [7:0]          rcon_q;
  logic [KEY_BITS-1:0] key_q;

  logic          accept, last, copy;
  logic [31:0]   key_col, prev_w, back_w, new_col;
  logic [AW-1:0] prev_addr, back_addr;

  assign accept = start_i && !busy_q && !ready_q && !invalidate_i;
  assign last   = (cnt_q == AW'(NCOL - 1));
  assign copy   = (cnt_q < AW'(NK));

  always_comb begin
    key_col = '0;
    for (int g = 0; g < NK; g++)
      if (cnt_q == AW'(g)) key_col = key_q[KEY_BITS-1-32*g -: 32];
  end

  assign prev_addr = cnt_q - AW'(1);
  assign back_addr = copy ? '0 : (cnt_q - AW'(NK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      cnt_q   <= '0;
      phase_q <= '0;
      rcon_q  <= 8'h01;
      key_q   <= '0;
    end else if (invalidate_i) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
    end else if (accept) begin
      key_q   <= key_i;
      busy_q  <= 1'b1;
      cnt_q   <= AW'(4);
      phase_q <= PH_W'(4 % NK);
      rcon_q  <= 8'h01;
    end else if (busy_q) begin
      cnt_q   <= cnt_q + AW'(1);
      phase_q <= (phase_q == PH_W'(NK - 1)) ? '0 : phase_q + PH_W'(1);
      if (phase_q == '0) rcon_q <= xtime(rcon_q);
      if (last) begin
        busy_q  <= 1'b0;
        ready_q <= 1'b1;
      end
    end
  end

  aes_kx_colgen #(
    .NK  (NK),
    .PH_W(PH_W)
  ) u_colgen (
    .prev_i   (prev_w),
    .back_i   (back_w),
    .key_col_i(key_col),
    .copy_i   (copy),
    .phase_i  (phase_q),
    .rcon_i   (rcon_q),
    .col_o    (new_col)
  );

  aes_kx_store #(
    .NCOL  (NCOL),
    .NR    (NR),
    .AW    (AW),
    .RIDX_W(RIDX_W)
  ) u_store (
    .clk_i      (clk_i),
    .init_i     (accept),
    .init_key_i (key_i[KEY_BITS-1 -: 128]),
    .we_i       (busy_q),
    .waddr_i    (cnt_q),
    .wdata_i    (new_col),
    .prev_addr_i(prev_addr),
    .back_addr_i(back_addr),
    .prev_o     (prev_w),
    .back_o     (back_w),
    .valid_i    (ready_q),
    .round_i    (rd_round_i),
    .reverse_i  (rd_reverse_i),
    .rkey_o     (rd_key_o)
  );

  assign ready_o = ready_q;

endmodule

// File: rtl/aes_key_expand_chk.sv
module aes_key_expand_chk #(
  parameter  int KEY_BITS = 128,
  localparam int NK       = KEY_BITS / 32,
  localparam int NR       = NK + 6,
  localparam int RIDX_W   = $clog2(NR + 1),
  localparam int EXP_CYC  = 4 * NR,
  localparam int CW       = $clog2(EXP_CYC + 1) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              invalidate_i,
  input logic              ready_o,
  input logic [RIDX_W-1:0] rd_round_i,
  input logic              rd_reverse_i,
  input logic [127:0]      rd_key_o
);

  logic          exp_q;
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= 1'b0;
      cyc_q <= '0;
    end else if (invalidate_i) begin
      exp_q <= 1'b0;
    end else if (!exp_q && !ready_o && start_i) begin
      exp_q <= 1'b1;
      cyc_q <= '0;
    end else if (exp_q) begin
      if (ready_o) exp_q <= 1'b0;
      else         cyc_q <= cyc_q + CW'(1);
    end
  end

  p_inv_clears_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalidate_i |=> !ready_o);

  p_ready_timing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (exp_q && cyc_q == CW'(EXP_CYC)));

  p_hold_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !invalidate_i) |=> ready_o);

  p_stable_key_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o) && $stable(rd_round_i) && $stable(rd_reverse_i)) |-> $stable(rd_key_o));

  p_zero_not_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (rd_key_o == '0));

  p_range_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && rd_round_i > RIDX_W'(NR)) |-> (rd_key_o == '0));

endmodule

bind aes_key_expand aes_key_expand_chk #(.KEY_BITS(KEY_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .invalidate_i(invalidate_i),
  .ready_o     (ready_o),
  .rd_round_i  (rd_round_i),
  .rd_reverse_i(rd_reverse_i),
  .rd_key_o    (rd_key_o)
);

// File: tb/aes_key_expand_bench.sv
`timescale 1ns/1ps
module aes_key_expand_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         start = 1'b0, inv = 1'b0, rev = 1'b0;
  logic [3:0]   rnd = '0;
  logic [255:0] key [3];
  logic         rdy [3];
  logic [127:0] rk  [3];

  bit [7:0]  sb  [256];
  bit [31:0] mdl [3][60];
  bit        mrdy [3];
  int        n_run = 0, n_fail = 0;

  aes_key_expand #(.KEY_BITS(128)) u_aes_key_expand (
    .clk_i(clk), .rst_ni(rst_n), .key_i(key[0][255:128]), .start_i(start), .invalidate_i(inv),
    .ready_o(rdy[0]), .rd_round_i(rnd), .rd_reverse_i(rev), .rd_key_o(rk[0]));

  aes_key_expand #(.KEY_BITS(192)) u_aes_key_expand_k192 (
    .clk_i(clk), .rst_ni(rst_n), .key_i(key[1][255:64]), .start_i(start), .invalidate_i(inv),
    .ready_o(rdy[1]), .rd_round_i(rnd), .rd_reverse_i(rev), .rd_key_o(rk[1]));

  aes_key_expand #(.KEY_BITS(256)) u_aes_key_expand_k256 (
    .clk_i(clk), .rst_ni(rst_n), .key_i(key[2]), .start_i(start), .invalidate_i(inv),
    .ready_o(rdy[2]), .rd_round_i(rnd), .rd_reverse_i(rev), .rd_key_o(rk[2]));

  function automatic int nk_of(input int c); return 4 + 2 * c; endfunction
  function automatic int nr_of(input int c); return nk_of(c) + 6; endfunction

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic init_sbox();
    bit [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic bit [31:0] subw(input bit [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  task automatic build(input int c);
    int nk, nr;
    bit [31:0] t;
    bit [7:0] rc;
    nk = nk_of(c); nr = nr_of(c); rc = 8'h01;
    for (int i = 0; i < nk; i++) mdl[c][i] = key[c][255-32*i -: 32];
    for (int i = nk; i < 4 * (nr + 1); i++) begin
      t = mdl[c][i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
      end else if (nk == 8 && i % nk == 4) begin
        t = subw(t);
      end
      mdl[c][i] = mdl[c][i-nk] ^ t;
    end
  endtask

  function automatic logic [127:0] exp_key(input int c, input int r, input bit rv);
    int rr;
    if (!mrdy[c] || r > nr_of(c)) return '0;
    rr = rv ? nr_of(c) - r : r;
    return {mdl[c][4*rr], mdl[c][4*rr+1], mdl[c][4*rr+2], mdl[c][4*rr+3]};
  endfunction

  task automatic check_rounds(input int c, input string ctx);
    string req;
    for (int r = 0; r < 16; r++) begin
      for (int rv = 0; rv < 2; rv++) begin
        rnd = 4'(r); rev = rv[0];
        #1;
        if (r > nr_of(c))  req = "R10";
        else if (rv == 1)  req = "R7";
        else if (r == 0)   req = "R2";
        else if (c == 2)   req = "R4";
        else               req = "R3";
        chk(req, $sformatf("%s cfg%0d round %0d rev %0d", ctx, c, r, rv), rk[c], exp_key(c, r, rv[0]));
      end
    end
    rnd = '0; rev = 1'b0;
  endtask

  // all tasks begin and end just after a falling edge
  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_inv();
    inv = 1'b1; @(negedge clk); inv = 1'b0;
    for (int c = 0; c < 3; c++) mrdy[c] = 1'b0;
  endtask

  task automatic new_keys();
    for (int c = 0; c < 3; c++)
      key[c] = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic t_reset();
    for (int c = 0; c < 3; c++) begin
      chk("R1", $sformatf("reset ready cfg%0d", c), 128'(rdy[c]), 128'(0));
      chk("R1", $sformatf("reset key cfg%0d", c), rk[c], '0);
    end
  endtask

  // start, check ready timing per size, then mark ready
  task automatic t_expand(input string ctx);
    for (int c = 0; c < 3; c++) build(c);
    pulse_start();
    for (int n = 1; n <= 56; n++) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
        if (n == 4 * nr_of(c) - 1) chk("R5", $sformatf("%s early ready cfg%0d", ctx, c), 128'(rdy[c]), 128'(0));
        if (n == 4 * nr_of(c))     chk("R5", $sformatf("%s ready cfg%0d", ctx, c), 128'(rdy[c]), 128'(1));
      end
      if (n == 20) chk("R8", $sformatf("%s zero while busy", ctx), rk[2], '0);
    end
    for (int c = 0; c < 3; c++) mrdy[c] = 1'b1;
    for (int c = 0; c < 3; c++) check_rounds(c, ctx);
  endtask

  task automatic t_known();
    rnd = 4'd0; rev = 1'b0; #1;
    chk("R2", "k128 round0", rk[0], 128'h2b7e151628aed2a6abf7158809cf4f3c);
    chk("R2", "k192 round0", rk[1], 128'h8e73b0f7da0e6452c810f32b809079e5);
    rnd = 4'd10; #1;
    chk("R3", "k128 round10", rk[0], 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    rnd = 4'd12; #1;
    chk("R3", "k192 round12", rk[1], 128'he98ba06f448c773c8ecc720401002202);
    rnd = 4'd14; #1;
    chk("R4", "k256 round14", rk[2], 128'hfe4890d1e6188d0b046df344706c631e);
    rnd = 4'd0; rev = 1'b1; #1;
    chk("R7", "k256 reverse0", rk[2], 128'hfe4890d1e6188d0b046df344706c631e);
    rev = 1'b0;
  endtask

  task automatic t_persist();
    repeat (300) @(negedge clk);
    for (int c = 0; c < 3; c++) check_rounds(c, "R6 persist");
  endtask

  task automatic t_start_when_ready();
    new_keys();
    pulse_start();
    repeat (70) @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      chk("R9", $sformatf("ready kept cfg%0d", c), 128'(rdy[c]), 128'(1));
      check_rounds(c, "R9 start while ready");
    end
  endtask

  task automatic t_invalidate();
    pulse_inv();
    for (int c = 0; c < 3; c++) begin
      chk("R8", $sformatf("inv ready cfg%0d", c), 128'(rdy[c]), 128'(0));
      chk("R8", $sformatf("inv key cfg%0d", c), rk[c], '0);
    end
  endtask

  task automatic t_abort();
    new_keys();
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_inv();
    repeat (70) @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      chk("R8", $sformatf("abort ready cfg%0d", c), 128'(rdy[c]), 128'(0));
      chk("R8", $sformatf("abort key cfg%0d", c), rk[c], '0);
    end
    t_expand("R11 after abort");
  endtask

  task automatic t_start_while_busy();
    pulse_inv();
    new_keys();
    for (int c = 0; c < 3; c++) build(c);
    pulse_start();
    repeat (10) @(negedge clk);
    new_keys();
    pulse_start();
    repeat (60) @(negedge clk);
    for (int c = 0; c < 3; c++) mrdy[c] = 1'b1;
    for (int c = 0; c < 3; c++) check_rounds(c, "R9 start while busy");
  endtask

  task automatic t_inv_and_start();
    pulse_inv();
    new_keys();
    start = 1'b1; inv = 1'b1;
    @(negedge clk);
    start = 1'b0; inv = 1'b0;
    repeat (70) @(negedge clk);
    for (int c = 0; c < 3; c++)
      chk("R12", $sformatf("inv beats start cfg%0d", c), 128'(rdy[c]), 128'(0));
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL R5 watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++) mrdy[c] = 1'b0;
    key[0] = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
    key[1] = {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0};
    key[2] = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
    init_sbox();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_expand("R5 first key");
    t_known();
    t_persist();
    t_start_when_ready();
    t_invalidate();
    new_keys();
    t_expand("R11 new key");
    t_abort();
    t_start_while_busy();
    t_inv_and_start();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule